// File: doc/BRIEF.md
# Interrupt Flag and Mask Register Pair

This block collects five one-cycle event pulses from a link datapath and turns them into a single interrupt line. Each pulse latches into a sticky flag bit of a byte-wide flag register. A byte-wide mask register selects which flags may raise the line. The line is registered. It is high in the cycle after any flag and its mask bit are both set.

Software reaches both bytes over a simple byte bus. The flag byte sits at offset 0x0C and the mask byte at offset 0x0D. Writing ones to the flag byte clears those flags. Writing ones to the mask byte turns those sources on. Zeros leave either byte unchanged. The three unused low bits of both bytes always read as ones.

Each bus cycle is decoded into one named access kind:
- `ACC_IDLE`: no select.
- `ACC_RD`: a read.
- `ACC_CLR_FLAG`: a write to the flag offset.
- `ACC_SET_MASK`: a write to the mask offset.
- `ACC_STRAY`: a write to any other offset.

Only `ACC_CLR_FLAG` and `ACC_SET_MASK` change state.

Top module: `irq_flag_bank`

## Requirements
- R1: After reset, both bytes read 0x07 and `irq` is 0.
- R2: Flag bit positions are: bit 7 transmit done, bit 6 receive done, bit 5 transmit underrun, bit 4 receive overflow, bit 3 serial gap. A pulse on an event input sets its bit at the next clock edge and touches no other bit.
- R3: A set flag stays set until software clears it.
- R4: A write to offset 0x0C clears each flag whose data bit is 1. Flags whose data bit is 0 keep their value.
- R5: A write to offset 0x0D sets each mask bit whose data bit is 1. Zero data bits leave the mask unchanged, and only reset clears the mask.
- R6: Bits 2..0 of both bytes read as 1 and ignore writes.
- R7: `irq` is 1 in the cycle after the flag and mask bytes share a set bit, and 0 in the cycle after they share none.
- R8: An event pulse in the same cycle as a clear write to that flag leaves the flag set.
- R9: Other offsets read 0x00, and writes to them change nothing. When `bus_sel` is low, `bus_rdata` is 0x00.
- R10: A read (`bus_wr` low) never changes either byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_tx_done | input | 1 | Transmit-done pulse |
| ev_rx_done | input | 1 | Receive-done pulse |
| ev_tx_under | input | 1 | Transmit-underrun pulse |
| ev_rx_over | input | 1 | Receive-overflow pulse |
| ev_gap | input | 1 | Serial-gap pulse |
| bus_sel | input | 1 | Bus cycle select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from offset |
| irq | output | 1 | Registered interrupt line |

## Verification
The functions that can collide are an event pulse setting a flag and a software clear of that same flag in one cycle. The bench provokes this with directed cycles that pulse every source while writing 0xF8 to offset 0x0C. It also provokes it throughout a random run where pulses and clear writes overlap freely. Each such cycle is judged by reading the flag byte afterwards and comparing it with a model in which the set takes priority over the clear. The same model also predicts `irq` one cycle later.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;
    // number of event sources and the byte bit of the lowest one
    localparam int NSRC   = 5;
    localparam int DATA_W = 8;
    localparam int LOW_W  = DATA_W - NSRC;

    typedef enum logic [2:0] {
        ACC_IDLE,
        ACC_RD,
        ACC_CLR_FLAG,
        ACC_SET_MASK,
        ACC_STRAY
    } acc_kind_e;
endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
    import irq_flag_pkg::*;
#(
    parameter int ADDR_W   = 5,
    parameter logic [ADDR_W-1:0] FLAG_OFS = 5'h0C,
    parameter logic [ADDR_W-1:0] MASK_OFS = 5'h0D
) (
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [NSRC-1:0]   clr_mask,
    output logic [NSRC-1:0]   set_mask
);
    acc_kind_e kind;

    always_comb begin
        if (!sel)                 kind = ACC_IDLE;
        else if (!wr)             kind = ACC_RD;
        else if (addr == FLAG_OFS) kind = ACC_CLR_FLAG;
        else if (addr == MASK_OFS) kind = ACC_SET_MASK;
        else                      kind = ACC_STRAY;
    end

    always_comb begin
        clr_mask = '0;
        set_mask = '0;
        unique case (kind)
            ACC_CLR_FLAG: clr_mask = wdata[DATA_W-1:LOW_W];
            ACC_SET_MASK: set_mask = wdata[DATA_W-1:LOW_W];
            ACC_IDLE, ACC_RD, ACC_STRAY: ;
            default: ;
        endcase
    end
endmodule

// File: rtl/irq_src_cell.sv
module irq_src_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic ev,
    input  logic clr,
    input  logic set_en,
    output logic flag_q,
    output logic mask_q
);
    // set wins over clear when both arrive together
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            mask_q <= 1'b0;
        end else begin
            if (ev)       flag_q <= 1'b1;
            else if (clr) flag_q <= 1'b0;
            if (set_en)   mask_q <= 1'b1;
        end
    end

    p_event_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ev |=> flag_q);
    p_flag_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr) |=> flag_q);
    p_clear_works_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !ev) |=> !flag_q);
    p_set_beats_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && ev) |=> flag_q);
    p_mask_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> mask_q);
    p_mask_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mask_q |=> mask_q);
endmodule

// File: rtl/irq_line_drive.sv
module irq_line_drive
    import irq_flag_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] flags,
    input  logic [NSRC-1:0] masks,
    output logic            irq
);
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |(flags & masks);
    end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
    import irq_flag_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter logic [ADDR_W-1:0] FLAG_OFS = 5'h0C,
    parameter logic [ADDR_W-1:0] MASK_OFS = 5'h0D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_tx_done,
    input  logic              ev_rx_done,
    input  logic              ev_tx_under,
    input  logic              ev_rx_over,
    input  logic              ev_gap,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    logic [NSRC-1:0] ev_vec, clr_mask, set_mask, flag_q, mask_q;

    // index 4 = byte bit 7 ... index 0 = byte bit 3
    assign ev_vec = {ev_tx_done, ev_rx_done, ev_tx_under, ev_rx_over, ev_gap};

    irq_bus_decode #(
        .ADDR_W(ADDR_W), .FLAG_OFS(FLAG_OFS), .MASK_OFS(MASK_OFS)
    ) u_decode (
        .sel(bus_sel), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .clr_mask(clr_mask), .set_mask(set_mask)
    );

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        irq_src_cell u_cell (
            .clk(clk), .rst_n(rst_n), .ev(ev_vec[i]), .clr(clr_mask[i]),
            .set_en(set_mask[i]), .flag_q(flag_q[i]), .mask_q(mask_q[i])
        );
    end

    irq_line_drive u_line (
        .clk(clk), .rst_n(rst_n), .flags(flag_q), .masks(mask_q), .irq(irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_sel) begin
            if (bus_addr == FLAG_OFS)      bus_rdata = {flag_q, {LOW_W{1'b1}}};
            else if (bus_addr == MASK_OFS) bus_rdata = {mask_q, {LOW_W{1'b1}}};
        end
    end

    p_irq_rises_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|(flag_q & mask_q)) |=> irq);
    p_irq_falls_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(flag_q & mask_q)) |=> !irq);
    p_low_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && (bus_addr == FLAG_OFS || bus_addr == MASK_OFS))
            |-> (&bus_rdata[LOW_W-1:0]));
    p_low_write_harmless_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_wdata[LOW_W-1:0] != '0
         && bus_wdata[DATA_W-1:LOW_W] == '0) |=> $stable(mask_q));
    p_read_harmless_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr) |=> $stable(mask_q));
    p_stray_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_addr != FLAG_OFS && bus_addr != MASK_OFS)
            |-> (bus_rdata == '0));
endmodule

// File: tb/irq_flag_bank_bench.sv
`timescale 1ns/1ps
module irq_flag_bank_bench;
    localparam logic [4:0] A_FLAG = 5'h0C;
    localparam logic [4:0] A_MASK = 5'h0D;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [4:0] ev = '0;
    logic sel = 1'b0, wr = 1'b0;
    logic [4:0] addr = '0;
    logic [7:0] wd = '0;
    logic [7:0] rdata;
    logic irq;

    int checks = 0, fails = 0;
    logic [4:0] m_flag = '0, m_mask = '0;
    logic m_irq = 1'b0;

    always #5 clk = ~clk;

    irq_flag_bank u_irq_flag_bank (
        .clk(clk), .rst_n(rst_n),
        .ev_tx_done(ev[4]), .ev_rx_done(ev[3]), .ev_tx_under(ev[2]),
        .ev_rx_over(ev[1]), .ev_gap(ev[0]),
        .bus_sel(sel), .bus_wr(wr), .bus_addr(addr), .bus_wdata(wd),
        .bus_rdata(rdata), .irq(irq)
    );

    function automatic logic [7:0] f_read(logic s, logic [4:0] a);
        if (!s)             return 8'h00;
        if (a == A_FLAG)    return {m_flag, 3'b111};
        if (a == A_MASK)    return {m_mask, 3'b111};
        return 8'h00;
    endfunction

    task automatic chk8(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // one bus/event cycle; checks rdata for reads and irq each cycle
    task automatic step(logic [4:0] e, logic s, logic w, logic [4:0] a,
                        logic [7:0] d, string tag);
        logic [4:0] clr;
        @(negedge clk);
        ev = e; sel = s; wr = w; addr = a; wd = d;
        #1;
        if (s && !w) chk8(tag, rdata, f_read(s, a));
        chk8("R7 irq", {7'd0, irq}, {7'd0, m_irq});
        @(posedge clk);
        clr = (s && w && a == A_FLAG) ? d[7:3] : 5'd0;
        m_irq = |(m_flag & m_mask);
        m_flag = (m_flag & ~clr) | e;
        if (s && w && a == A_MASK) m_mask = m_mask | d[7:3];
    endtask

    task automatic rd(logic [4:0] a, string tag);
        step(5'd0, 1'b1, 1'b0, a, 8'h00, tag);
    endtask

    initial begin
        #(200000 * 10);
        fails++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1 reset state
        #1; chk8("R1 irq", {7'd0, irq}, 8'd0);
        rd(A_FLAG, "R1 flag");
        rd(A_MASK, "R1 mask");
        chk8("R1 flag literal", {m_flag, 3'b111}, 8'h07);

        // R2 each source sets only its own bit; R4 clear it
        for (int i = 0; i < 5; i++) begin
            step(5'd1 << i, 1'b0, 1'b0, 5'd0, 8'h00, "R2");
            @(negedge clk); sel = 1'b1; wr = 1'b0; addr = A_FLAG; #1;
            chk8("R2 bit position", rdata, 8'h07 | (8'h08 << i));
            step(5'd0, 1'b1, 1'b1, A_FLAG, 8'h08 << i, "R4");
            rd(A_FLAG, "R4 cleared");
        end

        // R3 sticky, R4 zero-write no effect
        step(5'b10100, 1'b0, 1'b0, 5'd0, 8'h00, "R3");
        repeat (3) step(5'd0, 1'b0, 1'b0, 5'd0, 8'h00, "R3");
        step(5'd0, 1'b1, 1'b1, A_FLAG, 8'h00, "R4");
        rd(A_FLAG, "R3 R4 sticky");
        chk8("R3 literal", rdata, 8'hA7);
        // R6 low bits write ignored
        step(5'd0, 1'b1, 1'b1, A_MASK, 8'h07, "R6");
        step(5'd0, 1'b1, 1'b1, A_FLAG, 8'h07, "R6");
        rd(A_MASK, "R6 mask low");
        rd(A_FLAG, "R6 flag low");
        // R7 irq after mask set
        step(5'd0, 1'b1, 1'b1, A_MASK, 8'h80, "R5");
        rd(A_MASK, "R5 mask set");
        step(5'd0, 1'b0, 1'b0, 5'd0, 8'h00, "R7");
        step(5'd0, 1'b0, 1'b0, 5'd0, 8'h00, "R7");
        chk8("R7 irq high", {7'd0, irq}, 8'd1);
        // R5 writing zeros keeps mask
        step(5'd0, 1'b1, 1'b1, A_MASK, 8'h00, "R5");
        rd(A_MASK, "R5 zero write");
        // R8 event with clear same cycle
        step(5'b11111, 1'b1, 1'b1, A_FLAG, 8'hF8, "R8");
        rd(A_FLAG, "R8 set wins");
        chk8("R8 literal", rdata, 8'hFF);
        // R9 stray offsets; R10 reads harmless
        step(5'd0, 1'b1, 1'b1, 5'h1F, 8'hFF, "R9");
        step(5'd0, 1'b1, 1'b1, 5'h0E, 8'hFF, "R9");
        rd(5'h0E, "R9 stray read");
        rd(A_FLAG, "R9 R10 flag kept");
        step(5'd0, 1'b0, 1'b1, A_FLAG, 8'hFF, "R9 unselected");
        rd(A_FLAG, "R9 unselected write");
        step(5'd0, 1'b1, 1'b1, A_FLAG, 8'hF8, "R4");
        rd(A_FLAG, "R4 all clear");
        step(5'd0, 1'b0, 1'b0, 5'd0, 8'h00, "R7");
        step(5'd0, 1'b0, 1'b0, 5'd0, 8'h00, "R7 low");

        // random mix
        for (int n = 0; n < 600; n++) begin
            logic [4:0] e;
            logic [4:0] a;
            logic [1:0] pick;
            e = ($urandom % 3 == 0) ? 5'($urandom) : 5'd0;
            pick = 2'($urandom);
            a = (pick == 0) ? A_FLAG : (pick == 1) ? A_MASK :
                (pick == 2) ? A_FLAG : 5'($urandom);
            step(e, 1'($urandom), ($urandom % 4 == 0), a, 8'($urandom),
                 "R2 R3 R4 R5 R8 random");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule